// File: doc/BRIEF.md
# Interrupt Status-Word Swap Controller

This block keeps the 64-bit current status word of a processor and performs the automatic context swap when an interrupt is taken. Five request classes arrive as single-cycle pulses: machine check, program (with a 4-bit condition code), supervisor call, external and input/output. The mask bits in the current status word decide whether a request is eligible. A masked I/O or external request is kept pending until a later status word unmasks it. A masked program or machine-check condition is discarded. Supervisor calls cannot be masked.

Only one swap runs at a time. When a request is taken, the block writes an image of the current status word to that class's fixed "old" doubleword slot in memory. It then reads the class's fixed "new" doubleword, and the value read becomes current. Returning from a handler is a software decision. A load-status command (valid/ready) reads a doubleword from any address and makes it current. The command is refused in problem state, and the refusal raises a program-class interrupt.

Memory access uses one doubleword request channel. The block holds `mem_req_valid`, `mem_we`, `mem_addr` and `mem_wdata` stable until `mem_req_ready` is high at a clock edge, so the memory may stall for any number of cycles. Read data returns later on `mem_rsp_valid`/`mem_rsp_data`; the block accepts it with no back-pressure. The load-status command is accepted on a cycle where `lpsw_valid` and `lpsw_ready` are both high.

Top module: `psw_swap_ctrl`

## Requirements
- R1: After reset, `cur_psw` equals the RESET_PSW parameter (default zero: supervisor state, every class masked), `busy` is low and `mem_req_valid` is low.
- R2: When several eligible requests are pending together, they are served one swap at a time in this order: machine check, program, supervisor call, external, input/output.
- R3: A taken interrupt first writes to the class's old slot and then reads the class's new slot. The old slots are at byte addresses machine check 48, program 40, supervisor call 32, external 24 and I/O 56. Each new slot is its old slot plus 64. The doubleword read becomes `cur_psw`, and `busy` stays high from the write request until that doubleword is latched.
- R4: While `mem_req_valid` is high and `mem_req_ready` is low, the request fields stay unchanged. Each swap issues exactly one write and one read.
- R5: Status-word bit 0 enables I/O and bit 1 enables external. A request of either class that arrives while its bit is 0 stays pending. It is taken as soon as a status word with the bit set becomes current.
- R6: Status-word bit 2 enables program and bit 3 enables machine check. A request of either class that arrives while its bit is 0 is discarded and never causes a swap.
- R7: A supervisor-call request is taken whatever the mask bits are.
- R8: In supervisor state (status-word bit 4 = 0), an accepted load-status command makes exactly one read at `lpsw_addr` and no write. The doubleword read becomes `cur_psw`.
- R9: In problem state (bit 4 = 1), an accepted load-status command makes no access at `lpsw_addr`. It raises a program interrupt with condition code 2 instead.
- R10: The image written to an old slot is the current status word with the wait bit (bit 5) cleared. Bits 11:8 hold the condition code for a program interrupt and 0 for every other class. Bits 63:32 hold the instruction address and are copied unchanged.
- R11: `cur_psw` changes only on a cycle after `mem_rsp_valid` was high during a read. `lpsw_ready` is high only when no swap is running and no eligible request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_io | input | 1 | I/O request pulse |
| irq_ext | input | 1 | External request pulse |
| irq_svc | input | 1 | Supervisor-call request pulse |
| prog_valid | input | 1 | Program condition pulse |
| prog_code | input | 4 | Program condition code, sampled with prog_valid |
| mchk_valid | input | 1 | Machine-check pulse |
| lpsw_valid | input | 1 | Load-status command valid |
| lpsw_ready | output | 1 | Load-status command ready |
| lpsw_addr | input | ADDR_W | Byte address of the status word to load |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Doubleword byte address |
| mem_wdata | output | 64 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read data |
| cur_psw | output | 64 | Current status word |
| busy | output | 1 | A swap or load is in progress |

## Verification
The hardest case to reach from the ports is a chain of swaps in which each swap decides whether the next request is still eligible, because the masks change only when a new status word is loaded. The bench pulses all five classes in the same cycle. Every new slot holds a status word with all masks set, so each swap lets the next pending request through, and the write addresses show the service order. Pending and discarded requests are tested by first loading a fully masked word and then a fully unmasked one, and comparing the memory traffic that follows.

// File: rtl/psw_swap_pkg.sv
package psw_swap_pkg;
  localparam int NCLS   = 5;
  localparam int CLS_W  = 3;
  localparam int CODE_W = 4;

  // class index doubles as service priority (0 served first)
  typedef enum logic [CLS_W-1:0] {
    CL_MCHK = 3'd0,
    CL_PROG = 3'd1,
    CL_SVC  = 3'd2,
    CL_EXT  = 3'd3,
    CL_IO   = 3'd4
  } cls_e;

  localparam int F_EN_IO   = 0;
  localparam int F_EN_EXT  = 1;
  localparam int F_EN_PROG = 2;
  localparam int F_EN_MCHK = 3;
  localparam int F_PROBLEM = 4;
  localparam int F_WAIT    = 5;
  localparam int F_CODE_LO = 8;

  localparam logic [CODE_W-1:0] CODE_PRIV = 4'd2;
  localparam logic [7:0]        NEW_OFS   = 8'd64;

  function automatic logic [7:0] old_slot(input logic [CLS_W-1:0] c);
    case (c)
      CL_MCHK: old_slot = 8'd48;
      CL_PROG: old_slot = 8'd40;
      CL_SVC:  old_slot = 8'd32;
      CL_EXT:  old_slot = 8'd24;
      default: old_slot = 8'd56;
    endcase
  endfunction

  function automatic logic [7:0] new_slot(input logic [CLS_W-1:0] c);
    new_slot = old_slot(c) + NEW_OFS;
  endfunction

  // program and machine-check conditions are dropped when masked
  function automatic logic droppable(input int c);
    droppable = (c == int'(CL_PROG)) || (c == int'(CL_MCHK));
  endfunction

  function automatic logic [NCLS-1:0] class_enables(input logic [63:0] psw);
    class_enables = {psw[F_EN_IO], psw[F_EN_EXT], 1'b1,
                     psw[F_EN_PROG], psw[F_EN_MCHK]};
  endfunction
endpackage

// File: rtl/psw_irq_pend.sv
module psw_irq_pend
  import psw_swap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCLS-1:0]   set,
  input  logic [NCLS-1:0]   en,
  input  logic [NCLS-1:0]   clr,
  input  logic [CODE_W-1:0] code_in,
  output logic [NCLS-1:0]   elig,
  output logic [CODE_W-1:0] code_q
);
  logic [NCLS-1:0] pend_q;

  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    if (droppable(c)) begin : g_drop
      always_ff @(posedge clk) begin
        if (!rst_n) pend_q[c] <= 1'b0;
        else        pend_q[c] <= ((pend_q[c] & ~clr[c]) | set[c]) & en[c];
      end
    end else begin : g_hold
      always_ff @(posedge clk) begin
        if (!rst_n) pend_q[c] <= 1'b0;
        else        pend_q[c] <= (pend_q[c] & ~clr[c]) | set[c];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                           code_q <= '0;
    else if (set[CL_PROG] && en[CL_PROG]) code_q <= code_in;
  end

  assign elig = pend_q & en;
endmodule

// File: rtl/psw_irq_pick.sv
module psw_irq_pick
  import psw_swap_pkg::*;
(
  input  logic [NCLS-1:0]  req,
  output logic [NCLS-1:0]  grant,
  output logic [CLS_W-1:0] idx,
  output logic             any
);
  logic [NCLS:0] blocked;
  assign blocked[0] = 1'b0;

  for (genvar i = 0; i < NCLS; i++) begin : g_chain
    assign blocked[i+1] = blocked[i] | req[i];
    assign grant[i]     = req[i] & ~blocked[i];
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < NCLS; i++)
      if (grant[i]) idx = CLS_W'(i);
  end

  assign any = blocked[NCLS];
endmodule

// File: rtl/psw_swap_fsm.sv
module psw_swap_fsm
  import psw_swap_pkg::*;
#(
  parameter int          ADDR_W    = 24,
  parameter logic [63:0] RESET_PSW = 64'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              any,
  input  logic [CLS_W-1:0]  idx,
  input  logic [NCLS-1:0]   grant,
  input  logic [CODE_W-1:0] code_q,
  input  logic              lpsw_valid,
  input  logic [ADDR_W-1:0] lpsw_addr,
  output logic              lpsw_ready,
  output logic              reject,
  output logic [NCLS-1:0]   take_clr,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [63:0]       mem_wdata,
  input  logic              mem_rsp_valid,
  input  logic [63:0]       mem_rsp_data,
  output logic [63:0]       cur_psw,
  output logic              busy
);
  typedef enum logic [1:0] {ST_IDLE, ST_WR_OLD, ST_RD_NEW, ST_RD_WAIT} st_e;

  st_e               st_q;
  logic [ADDR_W-1:0] addr_q, next_addr_q;
  logic [63:0]       wdata_q;
  logic [63:0]       old_img;
  logic              idle;

  function automatic logic [ADDR_W-1:0] widen(input logic [7:0] a);
    widen = ADDR_W'(a);
  endfunction

  always_comb begin
    old_img = cur_psw;
    old_img[F_WAIT] = 1'b0;
    old_img[F_CODE_LO +: CODE_W] = (idx == CL_PROG) ? code_q : '0;
  end

  assign idle          = (st_q == ST_IDLE);
  assign busy          = !idle;
  assign lpsw_ready    = idle && !any;
  assign take_clr      = (idle && any) ? grant : '0;
  assign reject        = lpsw_ready && lpsw_valid && cur_psw[F_PROBLEM];
  assign mem_req_valid = (st_q == ST_WR_OLD) || (st_q == ST_RD_NEW);
  assign mem_we        = (st_q == ST_WR_OLD);
  assign mem_addr      = addr_q;
  assign mem_wdata     = wdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      cur_psw     <= RESET_PSW;
      addr_q      <= '0;
      next_addr_q <= '0;
      wdata_q     <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (any) begin
            addr_q      <= widen(old_slot(idx));
            next_addr_q <= widen(new_slot(idx));
            wdata_q     <= old_img;
            st_q        <= ST_WR_OLD;
          end else if (lpsw_valid && !cur_psw[F_PROBLEM]) begin
            addr_q <= lpsw_addr;
            st_q   <= ST_RD_NEW;
          end
        end
        ST_WR_OLD: if (mem_req_ready) begin
          addr_q <= next_addr_q;
          st_q   <= ST_RD_NEW;
        end
        ST_RD_NEW: if (mem_req_ready) st_q <= ST_RD_WAIT;
        default: if (mem_rsp_valid) begin
          cur_psw <= mem_rsp_data;
          st_q    <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/psw_swap_ctrl.sv
module psw_swap_ctrl
  import psw_swap_pkg::*;
#(
  parameter int          ADDR_W    = 24,
  parameter logic [63:0] RESET_PSW = 64'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_io,
  input  logic              irq_ext,
  input  logic              irq_svc,
  input  logic              prog_valid,
  input  logic [3:0]        prog_code,
  input  logic              mchk_valid,
  input  logic              lpsw_valid,
  output logic              lpsw_ready,
  input  logic [ADDR_W-1:0] lpsw_addr,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [63:0]       mem_wdata,
  input  logic              mem_rsp_valid,
  input  logic [63:0]       mem_rsp_data,
  output logic [63:0]       cur_psw,
  output logic              busy
);
  logic [NCLS-1:0]   set_v, en_v, clr_v, elig_v, grant_v;
  logic [CLS_W-1:0]  pick_idx;
  logic              pick_any, reject;
  logic [CODE_W-1:0] code_in, code_q;

  assign set_v   = {irq_io, irq_ext, irq_svc, prog_valid | reject, mchk_valid};
  assign code_in = reject ? CODE_PRIV : prog_code;
  assign en_v    = class_enables(cur_psw);

  psw_irq_pend u_pend (
    .clk(clk), .rst_n(rst_n), .set(set_v), .en(en_v), .clr(clr_v),
    .code_in(code_in), .elig(elig_v), .code_q(code_q)
  );

  psw_irq_pick u_pick (
    .req(elig_v), .grant(grant_v), .idx(pick_idx), .any(pick_any)
  );

  psw_swap_fsm #(.ADDR_W(ADDR_W), .RESET_PSW(RESET_PSW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .any(pick_any), .idx(pick_idx),
    .grant(grant_v), .code_q(code_q), .lpsw_valid(lpsw_valid),
    .lpsw_addr(lpsw_addr), .lpsw_ready(lpsw_ready), .reject(reject),
    .take_clr(clr_v), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .cur_psw(cur_psw), .busy(busy)
  );
endmodule

// File: rtl/psw_swap_ctrl_chk.sv
module psw_swap_ctrl_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic [63:0]       cur_psw,
  input logic              lpsw_ready,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [63:0]       mem_wdata,
  input logic              mem_rsp_valid
);
  // R4: a stalled request keeps all of its fields
  a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_we)
      && $stable(mem_addr) && $stable(mem_wdata));

  // R3: an accepted write is followed directly by the read request
  a_r3_write_then_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready && mem_we |=> mem_req_valid && !mem_we);

  // R3: writes target only the old-slot window, doubleword aligned
  a_r3_write_slot: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_we |-> mem_addr >= ADDR_W'(24)
      && mem_addr <= ADDR_W'(56) && mem_addr[2:0] == 3'd0);

  // R3: memory traffic only while busy
  a_r3_busy_cover: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> busy);

  // R11: status word moves only after returned read data
  a_r11_psw_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rsp_valid |=> $stable(cur_psw));

  // R11: commands accepted only when idle
  a_r11_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    lpsw_ready |-> !busy && !mem_req_valid);
endmodule

bind psw_swap_ctrl psw_swap_ctrl_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .cur_psw(cur_psw),
  .lpsw_ready(lpsw_ready), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_rsp_valid(mem_rsp_valid)
);

// File: tb/psw_swap_ctrl_tb_top.sv
module psw_swap_ctrl_tb_top;
  localparam int AW = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic irq_io = 0, irq_ext = 0, irq_svc = 0, prog_valid = 0, mchk_valid = 0;
  logic [3:0] prog_code = '0;
  logic lpsw_valid = 0, lpsw_ready;
  logic [AW-1:0] lpsw_addr = '0;
  logic mem_req_valid, mem_req_ready, mem_we;
  logic [AW-1:0] mem_addr;
  logic [63:0] mem_wdata, mem_rsp_data, cur_psw;
  logic mem_rsp_valid, busy;
  logic stall = 1'b0, tgl;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  psw_swap_ctrl #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_io(irq_io), .irq_ext(irq_ext),
    .irq_svc(irq_svc), .prog_valid(prog_valid), .prog_code(prog_code),
    .mchk_valid(mchk_valid), .lpsw_valid(lpsw_valid), .lpsw_ready(lpsw_ready),
    .lpsw_addr(lpsw_addr), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .cur_psw(cur_psw), .busy(busy)
  );

  // status words used by the tests
  localparam logic [63:0] PSW_A = {32'h0000_A000, 32'h0000_000F}; // @128
  localparam logic [63:0] PSW_Z = {32'h0000_D000, 32'h0000_0000}; // @136
  localparam logic [63:0] PSW_P = {32'h0000_C000, 32'h0000_001F}; // @144
  localparam logic [63:0] PSW_W = {32'h0000_B000, 32'h0000_002F}; // @152

  function automatic logic [63:0] new_of(input int old_addr);
    new_of = {32'h0001_0000 + 32'(old_addr), 32'h0000_000F};
  endfunction

  function automatic logic [63:0] init_val(input int i);
    if (i >= 11 && i <= 15) init_val = new_of(i * 8 - 64);
    else if (i == 16) init_val = PSW_A;
    else if (i == 17) init_val = PSW_Z;
    else if (i == 18) init_val = PSW_P;
    else if (i == 19) init_val = PSW_W;
    else init_val = '0;
  endfunction

  // memory model with traffic log
  logic [63:0] mem [32];
  int wr_cnt, rd_cnt;
  logic [AW-1:0] wr_addr [64];
  logic [63:0]   wr_data [64];
  logic [AW-1:0] rd_addr [64];

  assign mem_req_ready = stall ? tgl : 1'b1;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) mem[i] <= init_val(i);
      wr_cnt <= 0; rd_cnt <= 0; mem_rsp_valid <= 1'b0;
      mem_rsp_data <= '0; tgl <= 1'b0;
    end else begin
      tgl <= ~tgl;
      mem_rsp_valid <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        if (mem_we) begin
          mem[mem_addr[7:3]] <= mem_wdata;
          wr_addr[wr_cnt[5:0]] <= mem_addr;
          wr_data[wr_cnt[5:0]] <= mem_wdata;
          wr_cnt <= wr_cnt + 1;
        end else begin
          rd_addr[rd_cnt[5:0]] <= mem_addr;
          rd_cnt <= rd_cnt + 1;
          mem_rsp_valid <= 1'b1;
          mem_rsp_data  <= mem[mem_addr[7:3]];
        end
      end
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wait_quiet();
    int q = 0;
    int n = 0;
    while (q < 6 && n < 3000) begin
      @(negedge clk);
      n++;
      if (!busy && !mem_req_valid) q++; else q = 0;
    end
  endtask

  task automatic do_lpsw(input logic [AW-1:0] a);
    int n = 0;
    @(negedge clk);
    lpsw_valid = 1'b1; lpsw_addr = a;
    while (!lpsw_ready && n < 3000) begin @(negedge clk); n++; end
    @(negedge clk);
    lpsw_valid = 1'b0;
    wait_quiet();
  endtask

  task automatic pulse(input logic io, input logic ext, input logic svc,
                       input logic prg, input logic [3:0] code, input logic mck);
    @(negedge clk);
    irq_io = io; irq_ext = ext; irq_svc = svc;
    prog_valid = prg; prog_code = code; mchk_valid = mck;
    @(negedge clk);
    irq_io = 0; irq_ext = 0; irq_svc = 0; prog_valid = 0; mchk_valid = 0;
  endtask

  task automatic t_reset();
    chk("R1", "cur_psw", cur_psw, 64'h0);
    chk("R1", "busy", 64'(busy), 64'h0);
    chk("R1", "mem_req_valid", 64'(mem_req_valid), 64'h0);
  endtask

  task automatic t_load_sup();
    int wb = wr_cnt, rb = rd_cnt;
    do_lpsw(AW'(128));
    chk("R8", "reads", 64'(rd_cnt - rb), 64'd1);
    chk("R8", "read addr", 64'(rd_addr[rb[5:0]]), 64'd128);
    chk("R8", "writes", 64'(wr_cnt - wb), 64'd0);
    chk("R8", "cur_psw", cur_psw, PSW_A);
  endtask

  task automatic t_io_swap();
    int wb = wr_cnt, rb = rd_cnt;
    int n = 0;
    pulse(1, 0, 0, 0, 4'd0, 0);
    while (!busy && n < 100) begin @(negedge clk); n++; end
    chk("R3", "busy during swap", 64'(busy), 64'h1);
    chk("R11", "cur held while busy", cur_psw, PSW_A);
    wait_quiet();
    chk("R3", "old write addr", 64'(wr_addr[wb[5:0]]), 64'd56);
    chk("R10", "old image", wr_data[wb[5:0]], PSW_A);
    chk("R3", "new read addr", 64'(rd_addr[rb[5:0]]), 64'd120);
    chk("R3", "cur_psw after swap", cur_psw, new_of(56));
  endtask

  task automatic t_pending_io();
    int wb;
    do_lpsw(AW'(136));
    wb = wr_cnt;
    pulse(1, 0, 0, 0, 4'd0, 0);
    repeat (10) @(negedge clk);
    chk("R5", "masked io no write", 64'(wr_cnt - wb), 64'd0);
    chk("R5", "cur unchanged", cur_psw, PSW_Z);
    do_lpsw(AW'(128));
    chk("R5", "released io writes", 64'(wr_cnt - wb), 64'd1);
    chk("R5", "released io addr", 64'(wr_addr[wb[5:0]]), 64'd56);
    chk("R5", "released io cur", cur_psw, new_of(56));
  endtask

  task automatic t_drop();
    int wb;
    do_lpsw(AW'(136));
    wb = wr_cnt;
    pulse(0, 0, 0, 1, 4'd5, 1);
    repeat (4) @(negedge clk);
    do_lpsw(AW'(128));
    chk("R6", "dropped prog/mchk writes", 64'(wr_cnt - wb), 64'd0);
    chk("R6", "cur stays loaded", cur_psw, PSW_A);
  endtask

  task automatic t_priority();
    int wb = wr_cnt;
    pulse(1, 1, 1, 1, 4'd7, 1);
    wait_quiet();
    chk("R2", "swap count", 64'(wr_cnt - wb), 64'd5);
    chk("R2", "1st mchk", 64'(wr_addr[(wb + 0) % 64]), 64'd48);
    chk("R2", "2nd prog", 64'(wr_addr[(wb + 1) % 64]), 64'd40);
    chk("R2", "3rd svc", 64'(wr_addr[(wb + 2) % 64]), 64'd32);
    chk("R2", "4th ext", 64'(wr_addr[(wb + 3) % 64]), 64'd24);
    chk("R2", "5th io", 64'(wr_addr[(wb + 4) % 64]), 64'd56);
    chk("R10", "prog code field",
        wr_data[(wb + 1) % 64], {32'h0001_0030, 32'h0000_070F});
    chk("R10", "svc code zero", wr_data[(wb + 2) % 64], new_of(40));
    chk("R2", "final cur", cur_psw, new_of(56));
  endtask

  task automatic t_svc_masked();
    int wb;
    do_lpsw(AW'(136));
    wb = wr_cnt;
    pulse(0, 0, 1, 0, 4'd0, 0);
    wait_quiet();
    chk("R7", "svc write addr", 64'(wr_addr[wb[5:0]]), 64'd32);
    chk("R7", "svc image", wr_data[wb[5:0]], PSW_Z);
    chk("R7", "svc new cur", cur_psw, new_of(32));
  endtask

  task automatic t_wait_clear();
    int wb;
    do_lpsw(AW'(152));
    wb = wr_cnt;
    pulse(0, 1, 0, 0, 4'd0, 0);
    wait_quiet();
    chk("R10", "wait bit cleared", wr_data[wb[5:0]], {32'h0000_B000, 32'h0000_000F});
  endtask

  task automatic t_stall();
    int wb, rb;
    do_lpsw(AW'(128));
    wb = wr_cnt; rb = rd_cnt;
    stall = 1'b1;
    pulse(0, 1, 0, 0, 4'd0, 0);
    wait_quiet();
    stall = 1'b0;
    chk("R4", "one write under stall", 64'(wr_cnt - wb), 64'd1);
    chk("R4", "one read under stall", 64'(rd_cnt - rb), 64'd1);
    chk("R4", "write data under stall", wr_data[wb[5:0]], PSW_A);
    chk("R4", "read addr under stall", 64'(rd_addr[rb[5:0]]), 64'd88);
    chk("R4", "cur under stall", cur_psw, new_of(24));
  endtask

  task automatic t_reject();
    int wb, rb;
    do_lpsw(AW'(144));
    chk("R9", "problem state loaded", cur_psw, PSW_P);
    wb = wr_cnt; rb = rd_cnt;
    do_lpsw(AW'(136));
    chk("R9", "reads", 64'(rd_cnt - rb), 64'd1);
    chk("R9", "read is prog new slot", 64'(rd_addr[rb[5:0]]), 64'd104);
    chk("R9", "prog old addr", 64'(wr_addr[wb[5:0]]), 64'd40);
    chk("R9", "code 2 image", wr_data[wb[5:0]], {32'h0000_C000, 32'h0000_021F});
    chk("R9", "cur is prog handler", cur_psw, new_of(40));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load_sup();
    t_io_swap();
    t_pending_io();
    t_drop();
    t_priority();
    t_svc_masked();
    t_wait_clear();
    t_stall();
    t_reject();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule